// File: doc/BRIEF.md
# Weak Ordering Issue Controller

This block sits between a processor's stream of memory operations and a memory system that can keep several operations in flight and finish them in any order. Each operation arrives with a one-bit kind: an ordinary data access (load or store), or a synchronization operation. Data accesses go straight through and may overlap freely. A synchronization operation acts as a fence in both directions. It waits until every earlier operation has completed. Nothing behind it may issue until it has completed itself.

The controller keeps one counter of outstanding operations. The counter goes up on every issue and down on every completion pulse, and it has a configured ceiling. When an operation cannot issue, `in_ready` stays low in that cycle. The upstream side keeps presenting the same operation until it is accepted. An accepted operation appears on the issue port in the same cycle, carrying its kind and an opaque tag. The memory side always takes an issued operation. Completions come back as single-cycle pulses that carry no identity.

Top module: `wo_issue_ctrl`

## Requirements
- R1: After reset the outstanding count is 0, and an operation of either kind is accepted in the first cycle it is presented.
- R2: `in_kind` 0 means data and 1 means synchronization. An operation issues exactly when `in_valid` and `in_ready` are both high. In that cycle `iss_valid` is high and `iss_kind`/`iss_tag` equal `in_kind`/`in_tag`. `iss_valid` is low in every other cycle.
- R3: An issue with no counted completion raises `pend_cnt` by one on the next edge. A counted completion with no issue lowers it by one. If both happen in the same cycle, the count is unchanged.
- R4: `pend_cnt` never exceeds MAX_OUT. While it equals MAX_OUT, `in_ready` is low for data operations. It rises in the cycle after a completion brings the count below MAX_OUT.
- R5: A synchronization operation has `in_ready` low while `pend_cnt` is non-zero. It issues in the first cycle it is presented with `pend_cnt` at 0.
- R6: From the cycle after a synchronization operation issues until the cycle after its completion pulse, `in_ready` is low for operations of both kinds.
- R7: A completion pulse while `pend_cnt` is 0 is ignored. The count stays 0, or becomes 1 if an operation issues in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented |
| in_kind | input | 1 | 0 = data, 1 = synchronization |
| in_tag | input | TAG_W | Opaque tag carried to the issue port |
| in_ready | output | 1 | Operation may issue this cycle |
| iss_valid | output | 1 | Operation issued to memory this cycle |
| iss_kind | output | 1 | Kind of the issued operation |
| iss_tag | output | TAG_W | Tag of the issued operation |
| cmp_valid | input | 1 | One previously issued operation completed |
| pend_cnt | output | $clog2(MAX_OUT+1) | Outstanding operation count |

## Verification
The bench uses a small ceiling of three. It walks the controller through every count, including the full count, and through every mix of valid, kind and completion in a long pseudo-random sweep. A few directed sequences come before the sweep. The targeted corners are these:
- An issue and a completion in the same edge. A design that got this wrong would drift its count and either deadlock a later fence or let it leak early.
- A fence offered while data is still pending. A design that got this wrong would issue the fence too soon.
- Operations offered behind an incomplete fence. A design that got this wrong would let data overtake the fence.
- Completions arriving at a zero count. A design that got this wrong would wrap the counter to its maximum and stall for good.

// File: rtl/wo_pkg.sv
package wo_pkg;

    typedef enum logic {
        OP_DATA = 1'b0,
        OP_SYNC = 1'b1
    } op_kind_e;

    typedef struct packed {
        logic up;
        logic down;
    } cnt_step_t;

    function automatic int unsigned cnt_width(input int unsigned max_out);
        return (max_out < 1) ? 1 : $clog2(max_out + 1);
    endfunction

endpackage

// File: rtl/wo_out_counter.sv
module wo_out_counter
    import wo_pkg::*;
#(
    parameter int unsigned MAX_OUT = 8,
    parameter int unsigned CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic             done,
    output logic [CNT_W-1:0] count,
    output logic             at_max,
    output logic             is_zero,
    output logic             retire
);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_OUT);

    cnt_step_t step;

    assign is_zero = (count == '0);
    assign at_max  = (count == CMAX);
    assign retire  = done && !is_zero;

    always_comb begin
        step.up   = issue && !at_max;
        step.down = retire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case (step)
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/wo_fence_tracker.sv
module wo_fence_tracker
    import wo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fence_issue,
    input  logic retire,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (fence_issue) begin
            busy <= 1'b1;
        end else if (retire) begin
            busy <= 1'b0;
        end
    end
endmodule

// File: rtl/wo_issue_gate.sv
module wo_issue_gate
    import wo_pkg::*;
(
    input  logic     in_valid,
    input  op_kind_e kind,
    input  logic     fence_busy,
    input  logic     at_max,
    input  logic     is_zero,
    output logic     ready,
    output logic     fire,
    output logic     fence_fire
);
    always_comb begin
        ready = !fence_busy && !at_max;
        if (kind == OP_SYNC) begin
            ready = ready && is_zero;
        end
        fire       = in_valid && ready;
        fence_fire = fire && (kind == OP_SYNC);
    end
endmodule

// File: rtl/wo_issue_ctrl.sv
module wo_issue_ctrl
    import wo_pkg::*;
#(
    parameter int unsigned MAX_OUT = 8,
    parameter int unsigned TAG_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         in_valid,
    input  logic                         in_kind,
    input  logic [TAG_W-1:0]             in_tag,
    output logic                         in_ready,
    output logic                         iss_valid,
    output logic                         iss_kind,
    output logic [TAG_W-1:0]             iss_tag,
    input  logic                         cmp_valid,
    output logic [$clog2(MAX_OUT+1)-1:0] pend_cnt
);
    localparam int unsigned CNT_W = $clog2(MAX_OUT + 1);

    op_kind_e kind;
    logic     fire;
    logic     fence_fire;
    logic     fence_busy;
    logic     at_max;
    logic     is_zero;
    logic     retire;

    assign kind = op_kind_e'(in_kind);

    wo_issue_gate u_gate (
        .in_valid   (in_valid),
        .kind       (kind),
        .fence_busy (fence_busy),
        .at_max     (at_max),
        .is_zero    (is_zero),
        .ready      (in_ready),
        .fire       (fire),
        .fence_fire (fence_fire)
    );

    wo_out_counter #(
        .MAX_OUT (MAX_OUT),
        .CNT_W   (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .issue   (fire),
        .done    (cmp_valid),
        .count   (pend_cnt),
        .at_max  (at_max),
        .is_zero (is_zero),
        .retire  (retire)
    );

    wo_fence_tracker u_fence (
        .clk         (clk),
        .rst         (rst),
        .fence_issue (fence_fire),
        .retire      (retire),
        .busy        (fence_busy)
    );

    assign iss_valid = fire;
    assign iss_kind  = in_kind;
    assign iss_tag   = in_tag;
endmodule

// File: rtl/wo_issue_ctrl_chk.sv
module wo_issue_ctrl_chk #(
    parameter int unsigned MAX_OUT = 8,
    parameter int unsigned CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_kind,
    input logic             iss_valid,
    input logic             iss_kind,
    input logic             cmp_valid,
    input logic [CNT_W-1:0] pend_cnt
);
    localparam logic [CNT_W-1:0] CMAX = CNT_W'(MAX_OUT);

    p_issue_hs_r2: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> (in_valid && in_ready && iss_kind == in_kind));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= CMAX);

    p_hold_both_r3: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && cmp_valid && pend_cnt != '0) |=> $stable(pend_cnt));

    p_full_stall_r4: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt == CMAX) |-> !iss_valid);

    p_fence_drained_r5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_kind) |-> (pend_cnt == '0));

    p_fence_blocks_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_kind) |=> !iss_valid);

    p_zero_cmp_r7: assert property (@(posedge clk) disable iff (rst)
        (pend_cnt == '0 && !iss_valid) |=> (pend_cnt == '0));
endmodule

bind wo_issue_ctrl wo_issue_ctrl_chk #(
    .MAX_OUT (MAX_OUT),
    .CNT_W   ($clog2(MAX_OUT + 1))
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_kind   (in_kind),
    .iss_valid (iss_valid),
    .iss_kind  (iss_kind),
    .cmp_valid (cmp_valid),
    .pend_cnt  (pend_cnt)
);

// File: tb/tb_wo_issue_ctrl.sv
`timescale 1ns/1ps
module tb_wo_issue_ctrl;
    localparam int MAXO = 3;
    localparam int TW   = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_kind = 1'b0;
    logic [TW-1:0] in_tag = '0;
    logic          in_ready;
    logic          iss_valid;
    logic          iss_kind;
    logic [TW-1:0] iss_tag;
    logic          cmp_valid = 1'b0;
    logic [1:0]    pend_cnt;

    int total = 0;
    int bad   = 0;
    int m_cnt = 0;
    bit m_busy = 1'b0;
    bit last_zero_cmp = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wo_issue_ctrl #(.MAX_OUT(MAXO), .TAG_W(TW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
        .in_tag(in_tag), .in_ready(in_ready), .iss_valid(iss_valid),
        .iss_kind(iss_kind), .iss_tag(iss_tag), .cmp_valid(cmp_valid),
        .pend_cnt(pend_cnt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input bit k, input logic [TW-1:0] t, input bit c);
        bit exp_ready;
        bit issue;
        bit counted;
        string rq;
        @(negedge clk);
        chk(int'(pend_cnt) == m_cnt, last_zero_cmp ? "R7" : "R3", int'(pend_cnt), m_cnt);
        in_valid  = v;
        in_kind   = k;
        in_tag    = t;
        cmp_valid = c;
        #1;
        exp_ready = !m_busy && (m_cnt < MAXO) && (!k || m_cnt == 0);
        if (m_busy)                rq = "R6";
        else if (k && m_cnt != 0)  rq = "R5";
        else if (m_cnt == MAXO)    rq = "R4";
        else                       rq = "R2";
        chk(in_ready == exp_ready, rq, int'(in_ready), int'(exp_ready));
        issue = v && exp_ready;
        chk(iss_valid == issue, "R2", int'(iss_valid), int'(issue));
        if (issue) begin
            chk(iss_tag == t && iss_kind == k, "R2", int'({iss_kind, iss_tag}), int'({k, t}));
        end
        counted = c && (m_cnt > 0);
        last_zero_cmp = c && (m_cnt == 0);
        m_cnt = m_cnt + int'(issue) - int'(counted);
        if (issue && k)   m_busy = 1'b1;
        else if (counted) m_busy = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pend_cnt == 2'd0, "R1", int'(pend_cnt), 0);
        in_valid = 1'b1; in_kind = 1'b0; #1;
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        in_kind = 1'b1; #1;
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        in_valid = 1'b0;

        // R7: completions at zero count, with and without an issue
        step(0, 0, 4'h0, 1);
        step(1, 0, 4'h1, 1);
        step(0, 0, 4'h0, 1);
        // R4: fill to the ceiling and stall
        step(1, 0, 4'h2, 0);
        step(1, 0, 4'h3, 0);
        step(1, 0, 4'h4, 0);
        step(1, 0, 4'h4, 0);
        // R3: issue and completion in the same cycle at the ceiling-1
        step(1, 0, 4'h4, 1);
        step(1, 0, 4'h5, 1);
        // R5: fence waits for drain
        step(1, 1, 4'h6, 1);
        step(1, 1, 4'h6, 1);
        step(1, 1, 4'h6, 1);
        step(1, 1, 4'h6, 0);
        // R6: everything held behind the fence
        step(1, 0, 4'h7, 0);
        step(1, 1, 4'h8, 0);
        step(1, 0, 4'h7, 1);
        step(1, 0, 4'h7, 0);
        step(0, 0, 4'h0, 1);

        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 4000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[0] | lfsr[1], lfsr[2] & lfsr[3], lfsr[9:6], lfsr[4] | (lfsr[5] & lfsr[11]));
            end
        end
        step(0, 0, 4'h0, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule